// File: doc/BRIEF.md
# Toggle-Cell Conditional Write Controller

This controller writes words into an array of toggle-switched magnetic cells. In such a cell every word-line/bit-line pulse pair inverts the stored bit, whatever the bit held before. A plain write pulse therefore cannot set a value. For each write request the controller first reads the addressed word through a read port, compares it bit by bit with the incoming data, and then pulses only the columns whose bits differ.

A request is taken only while the block is idle. The controller captures the address, the data and three timing settings: the word-line width, the bit-line offset and the bit-line width, all in clock cycles. It then holds a read request until the read port acknowledges. The read result is compared in the acknowledge cycle, so no pulse can begin before the difference is known. If any bit differs, the shared word-line pulse starts first. The per-column bit-line enables follow after the offset. These enables carry no polarity, because the current always flows in one direction. A one-cycle done pulse closes every write, including a write that needed no pulse.

Top module: `tgl_wr_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, rd_req_o, wl_o, bl_o and done_o are all low.
- R2: When req_i is high and busy_o is low at a clock edge, rd_req_o is high from the next cycle, with rd_addr_o equal to the captured addr_i. It stays high and stable up to and including the cycle in which rd_ack_i is high.
- R3: When req_i is high while busy_o is high, it has no effect: no second read is started and the write in progress uses its own address and data.
- R4: wl_o and bl_o stay low while the block is idle and while the read is outstanding. No pulse starts before the cycle after rd_ack_i.
- R5: When rd_data_i equals the captured data, done_o is high in the cycle after the acknowledge, and no wl_o or bl_o pulse occurs for that write.
- R6: When the words differ, wl_o is high for exactly W cycles, starting the cycle after the acknowledge. W is wl_width_i, and a setting of 0 counts as 1.
- R7: bit-line enable bl_o[b] pulses only for each bit b where rd_data_i[b] differs from the captured data. It rises O cycles after wl_o rises, where O is bl_offset_i and a setting of 0 counts as 1. One pulse pair per differing bit leaves the cell equal to the write data.
- R8: Each bit-line enable stays high through cycle E-1, counted from the word-line start, where E = max(O + B, W). B is bl_width_i, and a setting of 0 counts as 1. Each enable therefore ends no earlier than wl_o.
- R9: done_o is high for exactly one cycle, in cycle E after the word-line start. busy_o is low in the following cycle. pulse_addr_o equals the captured address throughout the pulses.
- R10: Every write, including one that directly follows a write to the same address, issues its own read and compares against the value just read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, taken when busy_o is low |
| addr_i | input | AW | Write address |
| data_i | input | DW | Write data |
| wl_width_i | input | CW | Word-line pulse width in cycles (0 counts as 1) |
| bl_offset_i | input | CW | Bit-line start delay after word-line start (0 counts as 1) |
| bl_width_i | input | CW | Bit-line pulse width in cycles (0 counts as 1) |
| busy_o | output | 1 | A write is in progress |
| rd_req_o | output | 1 | Read request to the array read port |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read data valid, ends the read |
| rd_data_i | input | DW | Word read from the array |
| wl_o | output | 1 | Word-line pulse enable |
| bl_o | output | DW | Per-column single-direction bit-line enables |
| pulse_addr_o | output | AW | Address driven during the pulses |
| done_o | output | 1 | One-cycle write completion |

## Verification
The assertions assume that the read port raises rd_ack_i only while rd_req_o is high, and that rd_data_i is valid in that same cycle. The bench models the read port so that it acknowledges only during an outstanding read, after a delay of zero to two cycles. The assertions also assume that the timing inputs are steady in the cycle of a request. The bench changes those inputs only together with req_i and clears req_i one cycle later. A behavioural array inverts a bit on each bit-line rise that follows a word-line start, so the final cell contents show whether the comparison and the column mask were right.

// File: rtl/tgl_pkg.sv
package tgl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_PULSE = 2'd2,
    ST_DONE  = 2'd3
  } tgl_state_e;
endpackage

// File: rtl/tgl_req_cap.sv
module tgl_req_cap #(
  parameter int AW = 3,
  parameter int DW = 4,
  parameter int CW = 4,
  localparam int TW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] wl_width_i,
  input  logic [CW-1:0] bl_offset_i,
  input  logic [CW-1:0] bl_width_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [TW-1:0] wl_w_o,
  output logic [TW-1:0] off_o,
  output logic [TW-1:0] end_o
);
  logic [TW-1:0] wl_c, off_c, blw_c, bl_end_c, end_c;

  // zero settings count as one cycle; wl always starts before bl
  always_comb begin
    wl_c     = (wl_width_i  == '0) ? TW'(1) : TW'(wl_width_i);
    off_c    = (bl_offset_i == '0) ? TW'(1) : TW'(bl_offset_i);
    blw_c    = (bl_width_i  == '0) ? TW'(1) : TW'(bl_width_i);
    bl_end_c = off_c + blw_c;
    end_c    = (bl_end_c > wl_c) ? bl_end_c : wl_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
      wl_w_o <= TW'(1);
      off_o  <= TW'(1);
      end_o  <= TW'(2);
    end else if (cap_i) begin
      addr_o <= addr_i;
      data_o <= data_i;
      wl_w_o <= wl_c;
      off_o  <= off_c;
      end_o  <= end_c;
    end
  end
endmodule

// File: rtl/tgl_pulse_gen.sv
module tgl_pulse_gen #(
  parameter int DW = 4,
  parameter int CW = 4,
  localparam int TW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] mask_i,
  input  logic [TW-1:0] wl_w_i,
  input  logic [TW-1:0] off_i,
  input  logic [TW-1:0] end_i,
  output logic          wl_o,
  output logic [DW-1:0] bl_o,
  output logic          last_o
);
  logic          active_q;
  logic [TW-1:0] cnt_q;
  logic [DW-1:0] mask_q;
  logic          bl_win;

  assign last_o = active_q && (cnt_q == end_i - TW'(1));
  assign wl_o   = active_q && (cnt_q < wl_w_i);
  assign bl_win = active_q && (cnt_q >= off_i) && (cnt_q < end_i);

  for (genvar b = 0; b < DW; b++) begin : g_col
    assign bl_o[b] = bl_win && mask_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      mask_q   <= mask_i;
    end else if (last_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/tgl_wr_ctrl.sv
module tgl_wr_ctrl
  import tgl_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 4,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] wl_width_i,
  input  logic [CW-1:0] bl_offset_i,
  input  logic [CW-1:0] bl_width_i,
  output logic          busy_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wl_o,
  output logic [DW-1:0] bl_o,
  output logic [AW-1:0] pulse_addr_o,
  output logic          done_o
);
  localparam int TW = CW + 1;

  tgl_state_e    state_q, state_d;
  logic          cap, start, last;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, diff;
  logic [TW-1:0] wl_w, off, pend;

  assign cap   = (state_q == ST_IDLE) && req_i;
  assign diff  = rd_data_i ^ data_q;
  assign start = (state_q == ST_READ) && rd_ack_i && (diff != '0);

  tgl_req_cap #(.AW(AW), .DW(DW), .CW(CW)) cap_i (
    .clk_i, .rst_ni, .cap_i(cap), .addr_i, .data_i,
    .wl_width_i, .bl_offset_i, .bl_width_i,
    .addr_o(addr_q), .data_o(data_q), .wl_w_o(wl_w), .off_o(off), .end_o(pend)
  );

  tgl_pulse_gen #(.DW(DW), .CW(CW)) pgen_i (
    .clk_i, .rst_ni, .start_i(start), .mask_i(diff),
    .wl_w_i(wl_w), .off_i(off), .end_i(pend),
    .wl_o, .bl_o, .last_o(last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_READ;
      ST_READ:  if (rd_ack_i) state_d = (diff != '0) ? ST_PULSE : ST_DONE;
      ST_PULSE: if (last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign rd_req_o     = (state_q == ST_READ);
  assign done_o       = (state_q == ST_DONE);
  assign rd_addr_o    = addr_q;
  assign pulse_addr_o = addr_q;
endmodule

// File: rtl/tgl_wr_ctrl_chk.sv
module tgl_wr_ctrl_chk #(
  parameter int AW = 3,
  parameter int DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          wl_o,
  input logic [DW-1:0] bl_o,
  input logic [AW-1:0] pulse_addr_o,
  input logic          done_o
);
  AST_RST_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !busy_o && !rd_req_o && !wl_o && bl_o == '0 && !done_o) // R1
    else $error("AST_RST_QUIET");
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)) // R2
    else $error("AST_RD_HOLD");
  AST_IDLE_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wl_o && bl_o == '0) // R4
    else $error("AST_IDLE_NO_PULSE");
  AST_READ_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !wl_o && bl_o == '0) // R4
    else $error("AST_READ_NO_PULSE");
  AST_WL_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wl_o) |-> bl_o == '0) // R7
    else $error("AST_WL_LEADS");
  AST_BL_TRAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|bl_o) |-> !wl_o) // R8
    else $error("AST_BL_TRAILS");
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o) // R9
    else $error("AST_DONE_SINGLE");
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wl_o && bl_o == '0 && !rd_req_o) // R9
    else $error("AST_DONE_QUIET");
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wl_o && $past(wl_o) |-> $stable(pulse_addr_o)) // R9
    else $error("AST_ADDR_STABLE");
endmodule

bind tgl_wr_ctrl tgl_wr_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk_i, .rst_ni, .busy_o, .rd_req_o, .rd_addr_o, .rd_ack_i,
  .wl_o, .bl_o, .pulse_addr_o, .done_o
);

// File: tb/tgl_wr_ctrl_tb.sv
module tgl_wr_ctrl_tb_top;
  localparam int AW = 3;
  localparam int DW = 4;
  localparam int CW = 4;
  localparam int CLK_PERIOD = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [CW-1:0] wl_width_i = '0, bl_offset_i = '0, bl_width_i = '0;
  logic          busy_o, rd_req_o, rd_ack_i = 1'b0, wl_o, done_o;
  logic [AW-1:0] rd_addr_o, pulse_addr_o;
  logic [DW-1:0] rd_data_i = '0, bl_o;

  logic [DW-1:0] mem [2**AW];
  int errs = 0, checks = 0, cyc = 0;

  tgl_wr_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk_i, .rst_ni, .req_i, .addr_i, .data_i, .wl_width_i, .bl_offset_i, .bl_width_i,
    .busy_o, .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i, .wl_o, .bl_o, .pulse_addr_o, .done_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic int cl(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // one write; intr drives a competing request during the pulse phase
  task automatic do_write(input int a, input int d, input int dly,
                          input int ww, input int oo, input int bw, input bit intr);
    int w, o, b, e, k, done_k, wl_n, wl_first, wl_last;
    int bl_first [DW], bl_last [DW], bl_n [DW];
    logic [DW-1:0] mask, prev_bl;
    bit wl_seen, addr_ok;
    w = cl(ww); o = cl(oo); b = cl(bw);
    e = (o + b > w) ? o + b : w;
    @(negedge clk_i);
    chk(!busy_o, "R2 idle before request", busy_o, 0);
    req_i = 1'b1; addr_i = AW'(a); data_i = DW'(d);
    wl_width_i = CW'(ww); bl_offset_i = CW'(oo); bl_width_i = CW'(bw);
    @(negedge clk_i);
    req_i = 1'b0; addr_i = ~addr_i; data_i = ~data_i;
    for (int i = 0; i < dly; i++) begin
      chk(rd_req_o && rd_addr_o == AW'(a), "R2 read held", rd_addr_o, a);
      chk(!wl_o && bl_o == '0, "R4 no pulse while reading", bl_o, 0);
      if (i == 0 && intr) req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    chk(rd_req_o && rd_addr_o == AW'(a), "R10 fresh read issued", rd_req_o, 1);
    mask = mem[a] ^ DW'(d);
    rd_ack_i = 1'b1; rd_data_i = mem[a];
    @(negedge clk_i);
    rd_ack_i = 1'b0; rd_data_i = '0;
    wl_n = 0; wl_first = -1; wl_last = -1; done_k = -1; prev_bl = '0; wl_seen = 0; addr_ok = 1;
    for (int c = 0; c < DW; c++) begin bl_first[c] = -1; bl_last[c] = -1; bl_n[c] = 0; end
    for (k = 0; k < 64; k++) begin
      if (intr && k == 0) begin req_i = 1'b1; addr_i = AW'(a + 1); data_i = ~DW'(d); end
      else req_i = 1'b0;
      if (wl_o) begin
        wl_n++; if (wl_first < 0) wl_first = k; wl_last = k; wl_seen = 1;
        if (pulse_addr_o != AW'(a)) addr_ok = 0;
      end
      for (int c = 0; c < DW; c++) if (bl_o[c]) begin
        bl_n[c]++; if (bl_first[c] < 0) bl_first[c] = k; bl_last[c] = k;
        if (!prev_bl[c] && wl_seen) mem[pulse_addr_o][c] = ~mem[pulse_addr_o][c];
      end
      prev_bl = bl_o;
      if (done_o) begin done_k = k; break; end
      @(negedge clk_i);
    end
    req_i = 1'b0;
    if (mask == '0) begin
      chk(done_k == 0, "R5 done after ack", done_k, 0);
      chk(wl_n == 0 && bl_first[0] < 0 && bl_first[DW-1] < 0, "R5 no pulses", wl_n, 0);
    end else begin
      chk(wl_first == 0 && wl_n == w && wl_last == w - 1, "R6 wl width", wl_n, w);
      for (int c = 0; c < DW; c++) begin
        if (mask[c]) begin
          chk(bl_first[c] == o, "R7 bl offset", bl_first[c], o);
          chk(bl_last[c] == e - 1 && bl_n[c] == e - o, "R8 bl end", bl_last[c], e - 1);
        end else
          chk(bl_n[c] == 0, "R7 unmasked column quiet", bl_n[c], 0);
      end
      chk(done_k == e, "R9 done timing", done_k, e);
      chk(addr_ok, "R9 pulse address", addr_ok, 1);
    end
    chk(mem[a] == DW'(d), "R7 cell equals data", mem[a], d);
    @(negedge clk_i);
    chk(!busy_o && !done_o && !rd_req_o, "R9 idle after done", busy_o, 0);
    if (intr) chk(mem[(a + 1) % (2**AW)] != ~DW'(d) || mem[(a + 1) % (2**AW)] == 0,
                  "R3 busy request ignored", !busy_o, 1);
    if (intr) chk(!rd_req_o, "R3 no extra read", rd_req_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = '0;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !rd_req_o && !wl_o && bl_o == '0 && !done_o, "R1 reset state", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !rd_req_o && !wl_o && bl_o == '0 && !done_o, "R1 after release", busy_o, 0);
    // data sweep: every stored word against every write word
    for (int v = 0; v < 2**DW; v++)
      for (int d = 0; d < 2**DW; d++) begin
        mem[v % (2**AW)] = DW'(v);
        do_write(v % (2**AW), d, d % 3, 3, 1, 3, 1'b0);
      end
    // timing sweep, with zero settings
    for (int ww = 0; ww < 5; ww++)
      for (int oo = 0; oo < 5; oo++)
        for (int bw = 0; bw < 5; bw++) begin
          mem[2] = DW'(ww + oo);
          do_write(2, (ww * 5 + bw) % 16, bw % 3, ww, oo, bw, 1'b0);
        end
    // request while busy
    mem[4] = 4'h0; mem[5] = 4'h0;
    do_write(4, 9, 2, 2, 1, 2, 1'b1);
    chk(mem[5] == 4'h0, "R3 other cell untouched", mem[5], 0);
    // back-to-back writes to one address
    mem[6] = 4'h3;
    do_write(6, 12, 0, 2, 1, 1, 1'b0);
    do_write(6, 5, 0, 2, 1, 1, 1'b0);
    do_write(6, 5, 1, 2, 1, 1, 1'b0);
    chk(mem[6] == 4'h5, "R10 back-to-back result", mem[6], 5);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule